// File: doc/BRIEF.md
# Peripheral Soft-Reset Handshake Sequencer

This block runs the soft-reset handshake on one peripheral control register. It works without help from software. A one-cycle start request launches a fixed sequence of four phases. Every phase changes the soft-reset bit (bit 31) or the clock-gate bit (bit 30) through a read-modify-write, so all other register bits keep their values. The phase then polls the register until the bit shows the value that the phase waits for.

Polls are paced by a prescaled single-cycle tick input. The first poll of a phase happens only after a tick has arrived following the write. A phase whose bit never reaches the expected value within `MAX_POLLS` polls aborts the sequence. The register is reached through a plain request/acknowledge read/write port with one outstanding access at a time. When the sequence ends, the block pulses a done output, an error flag tells a clean finish from an abort, and a 2-bit code names the phase that timed out.

Top module: `soft_reset_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `reg_req_o` are 0 and `err_phase_o` is 0.
- R2: A start pulse seen while idle raises `busy_o` at the next clock edge. `busy_o` stays high until the edge at which the one-cycle `done_o` pulse appears. `busy_o` is low in the `done_o` cycle.
- R3: Every change to the register is a read followed by a write of the value read, with only bit 31 or bit 30 altered. With the initial value V, a successful run writes exactly five values in this order: V&~b31, then that value &~b30, then that value |b31, then the value read back &~b31, then that value &~b30.
- R4: Phase 0 clears bit 31 and waits for it to read 0. Phase 1 clears bit 30, sets bit 31, and waits for bit 30 to read 1. Phase 2 clears bit 31 and waits for it to read 0. Phase 3 clears bit 30 and waits for it to read 0. Success ends with `done_o`=1 and `err_o`=0.
- R5: Each poll read is issued only after a `tick_i` pulse that follows the phase's last write or the previous failed poll. With no ticks, no poll read is issued. A phase whose bit appears after L failed reads takes L+1 poll reads.
- R6: When a phase has made `MAX_POLLS` (default 1000) poll reads and none showed the expected value, the sequence aborts with `done_o`=1, `err_o`=1 and `err_phase_o` set to the phase number (0 to 3). No further register access follows.
- R7: A start pulse while `busy_o` is high is ignored. The write sequence is not disturbed and only one `done_o` pulse results.
- R8: `reg_req_o` stays high, with `reg_we_o` and `reg_wdata_o` stable, until the cycle in which `reg_ack_i` is high, and then drops. The `done_o` pulse is never high at the same time as `reg_req_o`.
- R9: `err_o` and `err_phase_o` keep their values after `done_o` until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| tick_i | input | 1 | Single-cycle poll pacing enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Sequence aborted on timeout |
| err_phase_o | output | 2 | Phase that timed out |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_wdata_o | output | DATA_W | Write data |
| reg_rdata_i | input | DATA_W | Read data, valid with acknowledge |
| reg_ack_i | input | 1 | Access acknowledge |

## Verification
The hardest case to reach from the ports is a timeout in a late phase. The earlier phases have to succeed, and the bit that the late phase polls must then stay wrong for all 1000 polls. The bench register model counts the writes it has accepted and forces the polled bit on reads only after a chosen number of writes. This lets each of the four phases fail on its own while the earlier phases complete normally. A lagging clock-gate response, a run with ticks held off, and a start pulse injected mid-run cover the retry path, the pacing rule and the busy-time rule.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [1:0] {
    OP_CLR  = 2'd0,
    OP_SET  = 2'd1,
    OP_POLL = 2'd2
  } op_e;

  // One micro-step of the handshake.
  typedef struct packed {
    op_e        op;
    logic       on_gate;  // 1: clock-gate bit, 0: soft-reset bit
    logic       want;     // expected bit value for OP_POLL
    logic [1:0] phase;
    logic       last;
  } step_t;

  localparam int NUM_STEPS = 9;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_RMW_RD,
    ST_RMW_WR,
    ST_WAIT_TICK,
    ST_POLL_RD
  } seq_state_e;

  // Step order is behaviour (R4): clear/poll per phase.
  function automatic step_t decode_step(input logic [STEP_W-1:0] idx);
    step_t s;
    s = '{op: OP_POLL, on_gate: 1'b0, want: 1'b0, phase: 2'd0, last: 1'b0};
    case (idx)
      4'd0: s = '{op: OP_CLR,  on_gate: 1'b0, want: 1'b0, phase: 2'd0, last: 1'b0};
      4'd1: s = '{op: OP_POLL, on_gate: 1'b0, want: 1'b0, phase: 2'd0, last: 1'b0};
      4'd2: s = '{op: OP_CLR,  on_gate: 1'b1, want: 1'b0, phase: 2'd1, last: 1'b0};
      4'd3: s = '{op: OP_SET,  on_gate: 1'b0, want: 1'b0, phase: 2'd1, last: 1'b0};
      4'd4: s = '{op: OP_POLL, on_gate: 1'b1, want: 1'b1, phase: 2'd1, last: 1'b0};
      4'd5: s = '{op: OP_CLR,  on_gate: 1'b0, want: 1'b0, phase: 2'd2, last: 1'b0};
      4'd6: s = '{op: OP_POLL, on_gate: 1'b0, want: 1'b0, phase: 2'd2, last: 1'b0};
      4'd7: s = '{op: OP_CLR,  on_gate: 1'b1, want: 1'b0, phase: 2'd3, last: 1'b0};
      4'd8: s = '{op: OP_POLL, on_gate: 1'b1, want: 1'b0, phase: 2'd3, last: 1'b1};
      default: s = '{op: OP_POLL, on_gate: 1'b0, want: 1'b0, phase: 2'd0, last: 1'b1};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/srs_bus_port.sv
// Single-outstanding request/acknowledge register access engine (R8).
module srs_bus_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              req_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              ack_i
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      wdata_o <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (req_o && ack_i) begin
        req_o  <= 1'b0;
        done_o <= 1'b1;
        if (!we_o) rdata_o <= rdata_i;
      end else if (go_i && !req_o) begin
        req_o   <= 1'b1;
        we_o    <= we_i;
        wdata_o <= we_i ? wdata_i : wdata_o;
      end
    end
  end

endmodule

// File: rtl/srs_poll_count.sv
// Poll-attempt counter for one wait phase (R6).
module srs_poll_count #(
  parameter int MAX_POLLS = 1000,
  localparam int CNT_W    = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  // Current read is the final allowed attempt.
  assign last_o = (cnt_q == LIMIT);

endmodule

// File: rtl/srs_sequencer.sv
// Step sequencer: read-modify-write and tick-paced polling (R2..R7, R9).
module srs_sequencer
  import srs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SRST_POS = 31,
  parameter int GATE_POS = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_phase_o,
  output logic              bus_go_o,
  output logic              bus_we_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_done_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  input  logic              cnt_last_i
);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  step_t             cur;
  logic              rd_bit;
  logic [DATA_W-1:0] mask;

  assign cur    = decode_step(step_q);
  assign mask   = cur.on_gate ? (DATA_W'(1) << GATE_POS) : (DATA_W'(1) << SRST_POS);
  assign rd_bit = |(bus_rdata_i & mask);

  // R3: only the selected bit changes.
  always_comb begin
    bus_go_o    = 1'b0;
    bus_we_o    = 1'b0;
    bus_wdata_o = (cur.op == OP_SET) ? (bus_rdata_i | mask) : (bus_rdata_i & ~mask);
    cnt_clr_o   = 1'b0;
    cnt_inc_o   = 1'b0;
    case (state_q)
      ST_ISSUE: begin
        if (cur.op == OP_POLL) cnt_clr_o = 1'b1;
        else bus_go_o = 1'b1;
      end
      ST_RMW_RD: begin
        if (bus_done_i) begin
          bus_go_o = 1'b1;
          bus_we_o = 1'b1;
        end
      end
      ST_WAIT_TICK: begin
        if (tick_i) bus_go_o = 1'b1;  // R5
      end
      ST_POLL_RD: begin
        if (bus_done_i && rd_bit != cur.want && !cnt_last_i) cnt_inc_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      step_q      <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      err_phase_o <= 2'd0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin  // R7: only accepted here
            busy_o      <= 1'b1;
            err_o       <= 1'b0;  // R9
            err_phase_o <= 2'd0;
            step_q      <= '0;
            state_q     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          state_q <= (cur.op == OP_POLL) ? ST_WAIT_TICK : ST_RMW_RD;
        end
        ST_RMW_RD: begin
          if (bus_done_i) state_q <= ST_RMW_WR;
        end
        ST_RMW_WR: begin
          if (bus_done_i) begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_WAIT_TICK: begin
          if (tick_i) state_q <= ST_POLL_RD;
        end
        ST_POLL_RD: begin
          if (bus_done_i) begin
            if (rd_bit == cur.want) begin
              if (cur.last) begin
                busy_o  <= 1'b0;
                done_o  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                step_q  <= step_q + 1'b1;
                state_q <= ST_ISSUE;
              end
            end else if (cnt_last_i) begin  // R6
              busy_o      <= 1'b0;
              done_o      <= 1'b1;
              err_o       <= 1'b1;
              err_phase_o <= cur.phase;
              state_q     <= ST_IDLE;
            end else begin
              state_q <= ST_WAIT_TICK;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/soft_reset_seq.sv
module soft_reset_seq #(
  parameter int DATA_W    = 32,
  parameter int SRST_POS  = 31,
  parameter int GATE_POS  = 30,
  parameter int MAX_POLLS = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_phase_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_ack_i
);

  logic              bus_go, bus_we, bus_done;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic              cnt_clr, cnt_inc, cnt_last;

  srs_sequencer #(
    .DATA_W(DATA_W), .SRST_POS(SRST_POS), .GATE_POS(GATE_POS)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_phase_o(err_phase_o),
    .bus_go_o(bus_go), .bus_we_o(bus_we), .bus_wdata_o(bus_wdata),
    .bus_done_i(bus_done), .bus_rdata_i(bus_rdata),
    .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc), .cnt_last_i(cnt_last)
  );

  srs_bus_port #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .go_i(bus_go), .we_i(bus_we), .wdata_i(bus_wdata),
    .done_o(bus_done), .rdata_o(bus_rdata),
    .req_o(reg_req_o), .we_o(reg_we_o), .wdata_o(reg_wdata_o),
    .rdata_i(reg_rdata_i), .ack_i(reg_ack_i)
  );

  srs_poll_count #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .inc_i(cnt_inc), .last_o(cnt_last)
  );

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              reg_req_o,
  input logic              reg_we_o,
  input logic [DATA_W-1:0] reg_wdata_o,
  input logic              reg_ack_i
);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_we_o) && $stable(reg_wdata_o)));

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_req_o && reg_ack_i) |=> !reg_req_o);

  // R8
  no_req_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !reg_req_o);

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> done_o);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind soft_reset_seq srs_checker #(.DATA_W(DATA_W)) u_srs_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .reg_req_o(reg_req_o), .reg_we_o(reg_we_o),
  .reg_wdata_o(reg_wdata_o), .reg_ack_i(reg_ack_i)
);

// File: tb/test_soft_reset_seq.sv
module test_soft_reset_seq;

  localparam logic [31:0] B31 = 32'h8000_0000;
  localparam logic [31:0] B30 = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        tick_i = 1'b0;
  logic        busy_o, done_o, err_o, reg_req_o, reg_we_o, reg_ack_i;
  logic [1:0]  err_phase_o;
  logic [31:0] reg_wdata_o, reg_rdata_i;

  soft_reset_seq i_soft_reset_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_phase_o(err_phase_o),
    .reg_req_o(reg_req_o), .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i), .reg_ack_i(reg_ack_i)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // register model state
  logic [31:0] model_q;
  int          ack_delay = 0, dly_cnt = 0;
  int          gate_lag = 0, gate_cnt = 0;
  bit          fault_en = 0, fault_val = 0;
  int          fault_k = 0, fault_pos = 31;
  int          wr_cnt = 0, rd_cnt = 0, rd_after_fault = 0, done_cnt = 0;
  bit          tick_en = 1;
  logic [31:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Register model, tick source and scoreboard monitor.
  always @(negedge clk) begin
    cycles++;
    tick_i <= tick_en && (cycles % 4 == 0);
    if (done_o) done_cnt++;
    if (reg_ack_i) begin
      reg_ack_i = 1'b0;
    end else if (reg_req_o) begin
      if (dly_cnt < ack_delay) dly_cnt++;
      else begin
        dly_cnt = 0;
        reg_ack_i = 1'b1;
        if (reg_we_o) begin
          // R3 monitor: compare against queued expectation
          if (exp_q.size() == 0)
            check(1'b0, "R3", "unexpected write", reg_wdata_o, 32'h0);
          else
            check(reg_wdata_o == exp_q[0], "R3", "write value", reg_wdata_o, exp_q[0]);
          if (exp_q.size() != 0) void'(exp_q.pop_front());
          model_q = reg_wdata_o;
          wr_cnt++;
          if (reg_wdata_o[31]) begin
            gate_cnt = gate_lag;
            if (gate_lag == 0) model_q[30] = 1'b1;
          end
        end else begin
          reg_rdata_i = model_q;
          if (fault_en && wr_cnt >= fault_k) begin
            reg_rdata_i[fault_pos] = fault_val;
            rd_after_fault++;
          end
          rd_cnt++;
          if (gate_cnt > 0) begin
            gate_cnt--;
            if (gate_cnt == 0) model_q[30] = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    reg_ack_i = 1'b0;
    reg_rdata_i = '0;
    model_q = '0;
  end

  // Watchdog
  initial begin
    wait (cycles > 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  // Driver: push the expected write list for a run.
  task automatic push_expect(input logic [31:0] v, input int nwr);
    logic [31:0] w[5];
    w[0] = v & ~B31;
    w[1] = w[0] & ~B30;
    w[2] = w[1] | B31;
    w[3] = (w[2] | B30) & ~B31;
    w[4] = w[3] & ~B30;
    for (int i = 0; i < nwr; i++) exp_q.push_back(w[i]);
  endtask

  task automatic prep(input logic [31:0] v, input int lag, input int adly);
    model_q = v; gate_lag = lag; gate_cnt = 0; ack_delay = adly;
    wr_cnt = 0; rd_cnt = 0; rd_after_fault = 0; done_cnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy_o && !done_o && !err_o && !reg_req_o && err_phase_o == 0,
          "R1", "reset outputs", {27'd0, busy_o, done_o, err_o, err_phase_o}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // Success run, no lag, immediate ack
    prep(32'hC000_1234, 0, 0);
    push_expect(32'hC000_1234, 5);
    pulse_start();
    check(busy_o, "R2", "busy after start", busy_o, 1);
    wait_done();
    check(!busy_o, "R2", "busy low at done", busy_o, 0);
    check(!err_o, "R4", "success err flag", err_o, 0);
    check(model_q == 32'h0000_1234, "R4", "final register", model_q, 32'h0000_1234);
    check(rd_cnt == 9, "R5", "read count lag0", rd_cnt, 9);
    @(negedge clk);
    check(!done_o, "R2", "done single cycle", done_o, 0);
    check(exp_q.size() == 0, "R3", "writes remaining", exp_q.size(), 0);

    // Lagging gate, slow ack, and mid-run start ignored (R7)
    prep(32'h0000_ABCD, 5, 2);
    push_expect(32'h0000_ABCD, 5);
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();  // R7: ignored while busy
    wait_done();
    repeat (30) @(negedge clk);
    check(done_cnt == 1, "R7", "done pulses", done_cnt, 1);
    check(wr_cnt == 5, "R7", "write count", wr_cnt, 5);
    check(rd_cnt == 14, "R5", "read count lag5", rd_cnt, 14);
    check(!err_o && !busy_o, "R4", "lag run status", {busy_o, err_o}, 0);

    // R5: no ticks -> no poll read
    prep(32'hC000_0001, 0, 1);
    push_expect(32'hC000_0001, 5);
    tick_en = 0;
    pulse_start();
    repeat (100) @(negedge clk);
    check(wr_cnt == 1 && rd_cnt == 1, "R5", "accesses without tick",
          {wr_cnt[15:0], rd_cnt[15:0]}, 32'h0001_0001);
    check(busy_o, "R5", "still busy without tick", busy_o, 1);
    tick_en = 1;
    wait_done();
    check(!err_o, "R5", "completes after ticks", err_o, 0);

    // R6 / R9: timeout in each phase
    for (int p = 0; p < 4; p++) begin
      int k;
      k = (p == 0) ? 1 : (p == 1) ? 3 : (p == 2) ? 4 : 5;
      prep(32'hC000_00F0 + p, 0, 0);
      push_expect(32'hC000_00F0 + p, k);
      fault_en = 1; fault_k = k;
      fault_pos = (p == 0 || p == 2) ? 31 : 30;
      fault_val = (p == 0 || p == 2 || p == 3);
      pulse_start();
      if (p > 0) check(!err_o, "R9", "err cleared by start", err_o, 0);
      wait_done();
      check(err_o, "R6", "timeout flag", err_o, 1);
      check(err_phase_o == p[1:0], "R6", "timeout phase", err_phase_o, p);
      check(rd_after_fault == 1000, "R6", "poll attempts", rd_after_fault, 1000);
      repeat (20) @(negedge clk);
      check(wr_cnt == k && exp_q.size() == 0, "R6", "no access after abort", wr_cnt, k);
      check(err_o && err_phase_o == p[1:0], "R9", "error held", {err_o, err_phase_o}, {1'b1, p[1:0]});
      fault_en = 0;
      exp_q.delete();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule